// File: doc/BRIEF.md
# Exception Priority Sequencing Controller

This block sits beside a processor core and decides which exception processing sequence the core begins next, and in which phase it may begin. Eight sources feed it: reset, address error, bus error, instruction-generated traps, illegal or privileged opcode faults, trace, hardware breakpoint and interrupt. Each source class has its own admission rule. Reset acts at once. Address and bus errors act at once as well, and they suspend any lower-priority work. Instruction traps start only while the instruction executes. Opcode faults start only while it decodes. Trace, breakpoint and interrupt wait for an instruction boundary or for the previous processing sequence to end.

The core reports its phase and pulses `seq_done` when a processing sequence ends. When several exceptions are pending, the controller starts them one after another in priority order, and each start pushes a new stack frame. When the chain runs out, it tells the core to fetch the vector of the last exception started. The handlers therefore run lowest priority first. Every output is registered, so an input that qualifies an action in one cycle shows its effect on the outputs in the next cycle.

Top module: `exc_seq_top`

## Requirements
- R1: After `rst`, and after every reset exception, `start` and `vec_fetch` stay low and requests are ignored until `reset_done` is sampled high. From the following cycle the controller accepts requests again.
- R2: A reset request starts code 0 in the next cycle, whatever the phase. That start has `abort`=1 and `ctx_push`=0. It clears every other pending request, including one raised in the same cycle.
- R3: Address error (code 1) and bus error (code 2) start in any phase, with `suspend`=1 and `ctx_push`=1. They also start while a sequence with a code above 2 is running, which preempts that sequence. When both are pending, address error goes first.
- R4: An instruction trap (code 3) starts only in the cycle after `in_execute` is sampled high with no sequence running.
- R5: An illegal or privileged opcode fault (code 4) starts only in the cycle after `in_decode` is sampled high with no sequence running.
- R6: Trace (code 5), hardware breakpoint (code 6) and interrupt (code 7) start only after `at_boundary` is sampled high with no sequence running, or after `seq_done` ends a sequence whose code is lower than their own.
- R7: Of the eligible pending requests, the lowest code starts first. When a sequence ends, the next eligible one starts in the next cycle, which gives back-to-back sequences in rising code order.
- R8: When `seq_done` ends a sequence and nothing else is eligible, `vec_fetch` pulses for one cycle with `vec_code` equal to the code of the last sequence started. It never pulses together with `start`.
- R9: `start` marks each sequence with a one-cycle pulse, with `code` valid alongside it. Every start with a nonzero code also pulses `ctx_push`.
- R10: A request stays latched until its sequence starts. The interrupt is the exception: it stays pending if its line is still high when its sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_addr_err | input | 1 | Address error request |
| req_bus_err | input | 1 | Bus error request |
| req_instr_trap | input | 1 | Instruction-generated trap request |
| req_illegal | input | 1 | Illegal, unimplemented or privileged opcode request |
| req_trace | input | 1 | Trace request |
| req_hw_bkpt | input | 1 | Hardware breakpoint request |
| req_irq | input | 1 | Interrupt request (level) |
| at_boundary | input | 1 | Core is at an instruction boundary |
| in_decode | input | 1 | Core is decoding an instruction |
| in_execute | input | 1 | Core is executing an instruction |
| seq_done | input | 1 | Current processing sequence has completed |
| reset_done | input | 1 | Reset processing has completed |
| start | output | 1 | One-cycle start of a processing sequence |
| code | output | 4 | Exception code of the sequence started |
| abort | output | 1 | Abort everything in progress (reset only) |
| suspend | output | 1 | Suspend work in progress and save internal context |
| ctx_push | output | 1 | Push a new stack frame |
| vec_fetch | output | 1 | Fetch the vector of the handler and resume |
| vec_code | output | 4 | Exception code whose handler is fetched |

## Verification
Two events can meet in a single cycle. The first case is the end of a sequence while another request is pending: the controller must choose between a chained start and a vector fetch. The bench drives `seq_done` with trace and interrupt requests pending. It expects the chained starts in rising code order and a single vector fetch only after the chain is empty. The second case is a reset request and a bus error raised in the same cycle, during a running sequence and with an interrupt pending. The bench expects only the aborting reset start, and no later start once `reset_done` arrives and a boundary is offered.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSRC   = 8;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] C_RESET = 4'd0;
  localparam logic [CODE_W-1:0] C_ADDR  = 4'd1;
  localparam logic [CODE_W-1:0] C_BUS   = 4'd2;
  localparam logic [CODE_W-1:0] C_TRAP  = 4'd3;
  localparam logic [CODE_W-1:0] C_ILL   = 4'd4;
  localparam logic [CODE_W-1:0] C_TRACE = 4'd5;
  localparam logic [CODE_W-1:0] C_HWBK  = 4'd6;
  localparam logic [CODE_W-1:0] C_IRQ   = 4'd7;

  typedef enum logic [2:0] {
    ADM_NOW,       // reset: any time
    ADM_SUSPEND,   // bus/address errors: any time, preempt lower work
    ADM_EXECUTE,   // within instruction execution
    ADM_DECODE,    // before instruction execution
    ADM_BOUNDARY   // after instruction or previous sequence
  } admit_e;

  function automatic admit_e admit_of(input int idx);
    if (idx == int'(C_RESET)) return ADM_NOW;
    if (idx <= int'(C_BUS))   return ADM_SUSPEND;
    if (idx == int'(C_TRAP))  return ADM_EXECUTE;
    if (idx == int'(C_ILL))   return ADM_DECODE;
    return ADM_BOUNDARY;
  endfunction
endpackage

// File: rtl/exc_pending.sv
module exc_pending
  import exc_pkg::*;
#(
  parameter int N       = NSRC,
  parameter int LVL_IDX = int'(C_IRQ)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept,
  input  logic         clear_all,
  input  logic [N-1:0] req,
  input  logic [N-1:0] take,
  output logic [N-1:0] pend_now
);
  logic [N-1:0] pend_q;
  logic [N-1:0] keep;

  assign pend_now = pend_q | (req & {N{accept}});

  always_comb begin
    keep          = '0;
    keep[LVL_IDX] = req[LVL_IDX];
  end

  always_ff @(posedge clk) begin
    if (rst || clear_all) pend_q <= '0;
    else                  pend_q <= (pend_now & ~take) | (take & keep);
  end
endmodule

// File: rtl/exc_elig.sv
module exc_elig
  import exc_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = CODE_W
) (
  input  logic         seq_active,
  input  logic         seq_done,
  input  logic [W-1:0] cur_code,
  input  logic         at_boundary,
  input  logic         in_decode,
  input  logic         in_execute,
  output logic [N-1:0] elig
);
  logic idle;
  logic ending;
  assign idle   = !seq_active;
  assign ending = seq_active && seq_done;

  for (genvar i = 0; i < N; i++) begin : g_e
    localparam admit_e ADM = admit_of(i);
    if (ADM == ADM_NOW) begin : g_now
      assign elig[i] = 1'b1;
    end else if (ADM == ADM_SUSPEND) begin : g_sus
      assign elig[i] = idle || ending || (cur_code > C_BUS);
    end else if (ADM == ADM_EXECUTE) begin : g_ex
      assign elig[i] = idle && in_execute;
    end else if (ADM == ADM_DECODE) begin : g_dec
      assign elig[i] = idle && in_decode;
    end else begin : g_bnd
      assign elig[i] = (idle && at_boundary) || (ending && (W'(i) > cur_code));
    end
  end
endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import exc_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = CODE_W
) (
  input  logic [N-1:0] cand,
  output logic         any,
  output logic [W-1:0] idx,
  output logic [N-1:0] grant
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !any) begin
        any      = 1'b1;
        idx      = W'(i);
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_reset,
  input  logic              req_addr_err,
  input  logic              req_bus_err,
  input  logic              req_instr_trap,
  input  logic              req_illegal,
  input  logic              req_trace,
  input  logic              req_hw_bkpt,
  input  logic              req_irq,
  input  logic              at_boundary,
  input  logic              in_decode,
  input  logic              in_execute,
  input  logic              seq_done,
  input  logic              reset_done,
  output logic              start,
  output logic [CODE_W-1:0] code,
  output logic              abort,
  output logic              suspend,
  output logic              ctx_push,
  output logic              vec_fetch,
  output logic [CODE_W-1:0] vec_code
);
  logic              waiting;
  logic              seq_active;
  logic [CODE_W-1:0] cur_code;
  logic [NSRC-1:0]   req_vec, pend_now, elig, grant, take;
  logic              any;
  logic [CODE_W-1:0] idx;
  logic              go, go_reset;

  assign req_vec = {req_irq, req_hw_bkpt, req_trace, req_illegal,
                    req_instr_trap, req_bus_err, req_addr_err, req_reset};

  exc_pending #(.N(NSRC), .LVL_IDX(int'(C_IRQ))) u_pend (
    .clk(clk), .rst(rst), .accept(!waiting), .clear_all(go_reset),
    .req(req_vec), .take(take), .pend_now(pend_now)
  );

  exc_elig #(.N(NSRC), .W(CODE_W)) u_elig (
    .seq_active(seq_active), .seq_done(seq_done), .cur_code(cur_code),
    .at_boundary(at_boundary), .in_decode(in_decode), .in_execute(in_execute),
    .elig(elig)
  );

  exc_pick #(.N(NSRC), .W(CODE_W)) u_pick (
    .cand(pend_now & elig), .any(any), .idx(idx), .grant(grant)
  );

  assign go       = any && !waiting;
  assign go_reset = go && (idx == C_RESET);
  assign take     = go ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting    <= 1'b1;
      seq_active <= 1'b0;
      cur_code   <= '0;
      start      <= 1'b0;
      code       <= '0;
      abort      <= 1'b0;
      suspend    <= 1'b0;
      ctx_push   <= 1'b0;
      vec_fetch  <= 1'b0;
      vec_code   <= '0;
    end else begin
      start     <= 1'b0;
      abort     <= 1'b0;
      suspend   <= 1'b0;
      ctx_push  <= 1'b0;
      vec_fetch <= 1'b0;
      if (waiting) begin
        if (reset_done) waiting <= 1'b0;
      end else if (go) begin
        start <= 1'b1;
        code  <= idx;
        if (go_reset) begin
          abort      <= 1'b1;
          waiting    <= 1'b1;
          seq_active <= 1'b0;
        end else begin
          ctx_push   <= 1'b1;
          suspend    <= (idx <= C_BUS);
          seq_active <= 1'b1;
          cur_code   <= idx;
        end
      end else if (seq_active && seq_done) begin
        vec_fetch  <= 1'b1;
        vec_code   <= cur_code;
        seq_active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
  import exc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_decode,
  input logic              in_execute,
  input logic              at_boundary,
  input logic              seq_done,
  input logic              reset_done,
  input logic              start,
  input logic [CODE_W-1:0] code,
  input logic              abort,
  input logic              suspend,
  input logic              ctx_push,
  input logic              vec_fetch
);
  logic w_q;
  always_ff @(posedge clk) begin
    if (rst)                          w_q <= 1'b1;
    else if (w_q && reset_done)       w_q <= 1'b0;
    else if (start && code == C_RESET) w_q <= !reset_done;
  end

  assert_quiet_wait_R1: assert property (@(posedge clk) disable iff (rst)
    w_q |-> (!start && !vec_fetch));

  assert_reset_abort_R2: assert property (@(posedge clk) disable iff (rst)
    (start && code == C_RESET) |-> (abort && !ctx_push));

  assert_fault_suspend_R3: assert property (@(posedge clk) disable iff (rst)
    (start && (code == C_ADDR || code == C_BUS)) |-> (suspend && ctx_push));

  assert_trap_in_exec_R4: assert property (@(posedge clk) disable iff (rst)
    (start && code == C_TRAP) |-> $past(in_execute));

  assert_ill_in_decode_R5: assert property (@(posedge clk) disable iff (rst)
    (start && code == C_ILL) |-> $past(in_decode));

  assert_late_group_R6: assert property (@(posedge clk) disable iff (rst)
    (start && code >= C_TRACE) |-> ($past(at_boundary) || $past(seq_done)));

  assert_no_vec_with_start_R8: assert property (@(posedge clk) disable iff (rst)
    !(start && vec_fetch));

  assert_push_each_R9: assert property (@(posedge clk) disable iff (rst)
    (start && code != C_RESET) |-> ctx_push);
endmodule

bind exc_seq_top exc_seq_chk u_chk (
  .clk(clk), .rst(rst), .in_decode(in_decode), .in_execute(in_execute),
  .at_boundary(at_boundary), .seq_done(seq_done), .reset_done(reset_done),
  .start(start), .code(code), .abort(abort), .suspend(suspend),
  .ctx_push(ctx_push), .vec_fetch(vec_fetch)
);

// File: tb/tb_exc_seq_top.sv
module tb_exc_seq_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_reset = 0, req_addr_err = 0, req_bus_err = 0, req_instr_trap = 0;
  logic req_illegal = 0, req_trace = 0, req_hw_bkpt = 0, req_irq = 0;
  logic at_boundary = 0, in_decode = 0, in_execute = 0, seq_done = 0, reset_done = 0;
  logic start, abort, suspend, ctx_push, vec_fetch;
  logic [3:0] code, vec_code;

  always #(PERIOD/2) clk = ~clk;

  exc_seq_top dut (
    .clk(clk), .rst(rst), .req_reset(req_reset), .req_addr_err(req_addr_err),
    .req_bus_err(req_bus_err), .req_instr_trap(req_instr_trap),
    .req_illegal(req_illegal), .req_trace(req_trace), .req_hw_bkpt(req_hw_bkpt),
    .req_irq(req_irq), .at_boundary(at_boundary), .in_decode(in_decode),
    .in_execute(in_execute), .seq_done(seq_done), .reset_done(reset_done),
    .start(start), .code(code), .abort(abort), .suspend(suspend),
    .ctx_push(ctx_push), .vec_fetch(vec_fetch), .vec_code(vec_code)
  );

  // {is_vec, code, abort, suspend, push}
  typedef struct packed {
    logic       is_vec;
    logic [3:0] c;
    logic       ab;
    logic       su;
    logic       pu;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic exp_start(input logic [3:0] c, input string tag);
    item_t it;
    it.is_vec = 1'b0; it.c = c;
    it.ab = (c == 4'd0); it.su = (c == 4'd1 || c == 4'd2); it.pu = (c != 4'd0);
    exp_q.push_back(it); tag_q.push_back(tag);
  endtask

  task automatic exp_vec(input logic [3:0] c, input string tag);
    item_t it;
    it = '0; it.is_vec = 1'b1; it.c = c;
    exp_q.push_back(it); tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && (start === 1'b1 || vec_fetch === 1'b1)) begin
      item_t got;
      got.is_vec = vec_fetch;
      got.c  = vec_fetch ? vec_code : code;
      got.ab = vec_fetch ? 1'b0 : abort;
      got.su = vec_fetch ? 1'b0 : suspend;
      got.pu = vec_fetch ? 1'b0 : ctx_push;
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R9 unexpected event actual=%b expected=none", got);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e || start === vec_fetch) begin
          miscompares++;
          $display("FAIL %s actual=%b expected=%b", t, got, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    req_reset = 0; req_addr_err = 0; req_bus_err = 0; req_instr_trap = 0;
    req_illegal = 0; req_trace = 0; req_hw_bkpt = 0;
    at_boundary = 0; in_decode = 0; in_execute = 0; seq_done = 0; reset_done = 0;
  endtask

  task automatic check_idle(input string tag);
    vectors++;
    if (start !== 1'b0 || vec_fetch !== 1'b0 || abort !== 1'b0 ||
        suspend !== 1'b0 || ctx_push !== 1'b0) begin
      miscompares++;
      $display("FAIL %s actual=%b%b%b%b%b expected=00000", tag,
               start, vec_fetch, abort, suspend, ctx_push);
    end
  endtask

  task automatic done_seq();
    seq_done = 1; step(); clear_in();
  endtask

  initial begin
    #(PERIOD*100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst = 0;
    // R1: wait state ignores requests
    req_trace = 1; at_boundary = 1; step();
    check_idle("R1 after rst");
    step(); check_idle("R1 hold");
    clear_in(); reset_done = 1; step(); clear_in();
    at_boundary = 1; step(); step(); clear_in();
    check_idle("R1 request ignored while waiting");

    // R4: trap waits for execute
    req_instr_trap = 1; at_boundary = 1; step(); clear_in();
    step(); check_idle("R4 no execute");
    in_execute = 1; exp_start(4'd3, "R4 trap start"); step(); clear_in();
    exp_vec(4'd3, "R8 trap vector"); done_seq();

    // R5: opcode fault waits for decode
    req_illegal = 1; in_execute = 1; step(); clear_in();
    check_idle("R5 no decode");
    in_decode = 1; exp_start(4'd4, "R5 illegal start"); step(); clear_in();
    exp_vec(4'd4, "R8 illegal vector"); done_seq();

    // R7/R10: trap + trace + irq chain, irq level held
    req_instr_trap = 1; req_trace = 1; req_irq = 1; in_execute = 1;
    exp_start(4'd3, "R7 chain first"); step(); clear_in();
    exp_start(4'd5, "R7 chain trace"); done_seq();
    exp_start(4'd7, "R6 chain irq"); done_seq();
    exp_vec(4'd7, "R8 chain vector lowest"); done_seq();
    req_irq = 0;
    at_boundary = 1; exp_start(4'd7, "R10 irq kept pending"); step(); clear_in();
    exp_vec(4'd7, "R8 irq vector"); done_seq();
    at_boundary = 1; step(); clear_in();
    check_idle("R10 irq cleared");

    // R3: bus error preempts trace
    req_trace = 1; at_boundary = 1; exp_start(4'd5, "R6 trace at boundary"); step(); clear_in();
    req_bus_err = 1; exp_start(4'd2, "R3 bus preempts"); step(); clear_in();
    exp_vec(4'd2, "R8 bus vector"); done_seq();

    // R3: address before bus
    req_addr_err = 1; req_bus_err = 1;
    exp_start(4'd1, "R3 addr first"); step(); clear_in();
    exp_start(4'd2, "R3 bus after addr"); done_seq();
    exp_vec(4'd2, "R8 bus vector 2"); done_seq();

    // R6/R7: breakpoint and interrupt together
    req_hw_bkpt = 1; req_irq = 1; at_boundary = 1;
    exp_start(4'd6, "R7 bkpt first"); step(); clear_in(); req_irq = 0;
    exp_start(4'd7, "R7 irq next"); done_seq();
    exp_vec(4'd7, "R8 irq vector 2"); done_seq();

    // R2: reset and bus error together, pending irq cleared
    req_trace = 1; at_boundary = 1; exp_start(4'd5, "R6 trace again"); step(); clear_in();
    req_irq = 1; step(); req_irq = 0;
    req_reset = 1; req_bus_err = 1; exp_start(4'd0, "R2 reset wins"); step(); clear_in();
    at_boundary = 1; req_trace = 1; step(); clear_in();
    check_idle("R1 wait after reset exception");
    reset_done = 1; step(); clear_in();
    at_boundary = 1; step(); step(); clear_in();
    check_idle("R2 pending cleared");

    step(); step();
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R9 missing events actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule